// File: doc/BRIEF.md
# Symbol Error Applier for a 12-bit-Symbol Page Buffer

This block sits after a Reed-Solomon decoder that works on 12-bit symbols. It takes the decoder's correction reports one at a time. Each report is a symbol position and a 12-bit error pattern. The block applies each report to a byte-wide page buffer. The buffer holds 2048 data bytes, and a spare area follows at byte address 2048.

Every two symbols occupy three bytes. Symbol 0 is short and holds only 8 bits. Every later symbol starts at buffer bit `12*p - 4`, counting bits from the most significant bit of byte 0. A symbol therefore touches one byte (position 0) or two neighbouring bytes. Symbol 1365 straddles the last data byte and the first spare byte.

The block updates each touched byte with a read-modify-write on an external single-port byte RAM. The RAM has one cycle of read latency. The block counts the symbols it applies. Two cases mark the page as uncorrectable: a position beyond the last symbol, and a position-0 pattern that uses its top four bits. After that, no further buffer writes happen for the page. When the decoder signals the end of the page, the block emits a one-cycle done pulse that carries the count and the failure flag.

Top module: `symfix_apply`

## Requirements
- R1: After reset, `rep_ready` is 1, `mem_en` is 0 and `done` is 0.
- R2: For an odd position p, byte floor(3p/2) is XORed with pattern[11:4], and byte floor(3p/2)+1 is XORed with {pattern[3:0], 4'h0}.
- R3: For an even position p > 0, byte 3p/2-1 is XORed with {4'h0, pattern[11:8]}, and byte 3p/2 is XORed with pattern[7:0].
- R4: Position 0 with pattern[11:8] = 0 reads and writes only byte 0, XORing it with pattern[7:0], and counts as one applied symbol.
- R5: Position 0 with any of pattern[11:8] set causes no buffer access and sets the uncorrectable flag for the page.
- R6: A position above 1374 causes no buffer access and sets the uncorrectable flag for the page.
- R7: Position 1365 updates byte 2047 with pattern[11:4] and buffer address 2048 (spare byte 0) with {pattern[3:0], 4'h0}.
- R8: Positions 1366 to 1374 land in the spare area using the odd/even rules above; spare byte k sits at buffer address 2048+k, and no access leaves the buffer.
- R9: Each byte update is a read cycle (`mem_en`=1, `mem_we`=0), then a write cycle to the same address with `mem_wdata` = read data XOR value. The lower address is updated first. A two-byte report takes four cycles, and `rep_ready` is low from the cycle after acceptance until the last write.
- R10: Once a page is uncorrectable, later reports of that page are still accepted but are dropped: no buffer access, and they are not counted.
- R11: After `page_end`, and once pending updates finish, `done` pulses for exactly one cycle with `done_count` (applied symbols, saturating) and `done_fail`. The count and flag then clear for the next page.
- R12: From the cycle after `page_end` until the done pulse, `rep_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rep_valid | input | 1 | Correction report present |
| rep_ready | output | 1 | Block can take a report |
| rep_pos | input | POS_W (11) | Symbol position |
| rep_pat | input | 12 | Error pattern |
| page_end | input | 1 | Pulse: no more reports for this page |
| mem_en | output | 1 | Buffer RAM access enable |
| mem_we | output | 1 | Buffer RAM write (1) or read (0) |
| mem_addr | output | ADDR_W (12) | Buffer byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after a read |
| done | output | 1 | One-cycle end-of-page strobe |
| done_count | output | CNT_W (8) | Symbols applied in the page |
| done_fail | output | 1 | Page was uncorrectable |

## Verification
Some behaviours are checked by the embedded assertions on every cycle:
- every write is preceded by a read of the same address, and every read is followed by a write;
- accesses stay inside the buffer;
- nothing touches memory while the page is marked failed;
- `rep_ready` drops after `page_end`;
- `done` never lasts two cycles.

Other behaviours can only be shown by the bench's scenarios, which compare against a bit-offset model:
- the exact byte addresses and XOR values for odd, even, zero, boundary and spare positions;
- overlapping symbols that share a byte;
- dropped reports after a failure;
- the per-page count and its clearing.

// File: rtl/symfix_pkg.sv
// Shared definitions for the symbol error applier.
// Assumes 12-bit symbols packed into 8-bit bytes, two symbols per three bytes.
package symfix_pkg;
    localparam int SYM_W  = 12;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Read-modify-write sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_WR0,
        ST_RD1,
        ST_WR1
    } rmw_state_t;
endpackage

// File: rtl/symfix_map.sv
// Maps one symbol position and pattern onto one or two byte updates.
// Purely combinational. Assumes symbol p>0 starts at bit 12p-4 of the buffer.
// Position 0 is an 8-bit symbol. Positions above MAX_POS are rejected.
module symfix_map
    import symfix_pkg::*;
#(
    parameter int POS_W   = 11,
    parameter int ADDR_W  = 12,
    parameter int MAX_POS = 1374
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [SYM_W-1:0]  pat,
    output logic              ok,
    output logic              pair,
    output logic [ADDR_W-1:0] addr0,
    output byte_t             val0,
    output logic [ADDR_W-1:0] addr1,
    output byte_t             val1
);
    localparam int TRI_W = POS_W + 2;

    logic [TRI_W-1:0] tri3;
    logic [TRI_W-2:0] base;

    // Byte index of 3p/2, rounded down
    always_comb begin
        tri3 = {2'b00, pos} + {1'b0, pos, 1'b0};
        base = tri3[TRI_W-1:1];
    end

    // Select addresses and XOR values by position class
    always_comb begin
        ok    = 1'b1;
        pair  = 1'b1;
        addr0 = '0;
        addr1 = '0;
        val0  = '0;
        val1  = '0;
        if (pos > POS_W'(MAX_POS)) begin
            ok   = 1'b0;
            pair = 1'b0;
        end else if (pos == '0) begin
            pair  = 1'b0;
            val0  = pat[7:0];
            ok    = (pat[11:8] == 4'h0);
        end else if (pos[0]) begin
            addr0 = ADDR_W'(base);
            val0  = pat[11:4];
            addr1 = ADDR_W'(base + (TRI_W-1)'(1));
            val1  = {pat[3:0], 4'h0};
        end else begin
            addr0 = ADDR_W'(base - (TRI_W-1)'(1));
            val0  = {4'h0, pat[11:8]};
            addr1 = ADDR_W'(base);
            val1  = pat[7:0];
        end
    end
endmodule

// File: rtl/symfix_rmw.sv
// Read-modify-write sequencer for up to two byte updates per report.
// Assumes a single-port byte RAM with one cycle of read latency.
// Each byte takes one read cycle and one write cycle. The lower address goes first.
module symfix_rmw
    import symfix_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              pair,
    input  logic [ADDR_W-1:0] addr0,
    input  byte_t             val0,
    input  logic [ADDR_W-1:0] addr1,
    input  byte_t             val1,
    output logic              idle,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output byte_t             mem_wdata,
    input  byte_t             mem_rdata
);
    rmw_state_t        state;
    logic              pair_q;
    logic [ADDR_W-1:0] a0_q, a1_q;
    byte_t             v0_q, v1_q;
    logic              first_half;

    // Capture the update plan when a report is launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= 1'b0;
            a0_q   <= '0;
            a1_q   <= '0;
            v0_q   <= '0;
            v1_q   <= '0;
        end else if (go) begin
            pair_q <= pair;
            a0_q   <= addr0;
            a1_q   <= addr1;
            v0_q   <= val0;
            v1_q   <= val1;
        end
    end

    // Step through read and write phases for each byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (go) state <= ST_RD0;
                ST_RD0:  state <= ST_WR0;
                ST_WR0:  state <= pair_q ? ST_RD1 : ST_IDLE;
                ST_RD1:  state <= ST_WR1;
                ST_WR1:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the RAM port from the current phase
    always_comb begin
        first_half = (state == ST_RD0) || (state == ST_WR0);
        idle       = (state == ST_IDLE);
        mem_en     = !idle;
        mem_we     = (state == ST_WR0) || (state == ST_WR1);
        mem_addr   = first_half ? a0_q : a1_q;
        mem_wdata  = mem_rdata ^ (first_half ? v0_q : v1_q);
    end

    // R9
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ($past(mem_en) && !$past(mem_we) && ($past(mem_addr) == mem_addr)));

    // R9
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_en && mem_we));
endmodule

// File: rtl/symfix_tally.sv
// Per-page bookkeeping: applied-symbol count, failure flag, end-of-page strobe.
// Assumes page_end may arrive while updates are in flight; done waits for idle.
module symfix_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ok_hit,
    input  logic             bad_hit,
    input  logic             page_end,
    input  logic             idle,
    output logic             fail_q,
    output logic             end_pend,
    output logic             done,
    output logic [CNT_W-1:0] done_count,
    output logic             done_fail
);
    logic [CNT_W-1:0] cnt;
    logic             fire;

    // Finish the page once the sequencer is quiet
    always_comb fire = idle && end_pend && !done;

    // Track pending end-of-page requests
    always_ff @(posedge clk) begin
        if (!rst_n)        end_pend <= 1'b0;
        else if (page_end) end_pend <= 1'b1;
        else if (fire)     end_pend <= 1'b0;
    end

    // Count applied symbols (saturating) and latch failure
    always_ff @(posedge clk) begin
        if (!rst_n || fire) begin
            cnt    <= '0;
            fail_q <= 1'b0;
        end else begin
            if (ok_hit && (cnt != {CNT_W{1'b1}})) cnt <= cnt + 1'b1;
            if (bad_hit) fail_q <= 1'b1;
        end
    end

    // Present the result for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            done_count <= '0;
            done_fail  <= 1'b0;
        end else begin
            done <= fire;
            if (fire) begin
                done_count <= cnt;
                done_fail  <= fail_q;
            end
        end
    end

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/symfix_apply.sv
// Top: accepts correction reports, maps them to byte updates, applies them to
// the page buffer through a single-port RAM, and reports per page.
// Assumes a buffer of DATA_BYTES data bytes followed by SPARE_BYTES spare bytes.
module symfix_apply
    import symfix_pkg::*;
#(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int MAX_POS     = 1374,
    parameter int POS_W       = 11,
    parameter int CNT_W       = 8,
    parameter int ADDR_W      = $clog2(DATA_BYTES + SPARE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rep_valid,
    output logic              rep_ready,
    input  logic [POS_W-1:0]  rep_pos,
    input  logic [SYM_W-1:0]  rep_pat,
    input  logic              page_end,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              done,
    output logic [CNT_W-1:0]  done_count,
    output logic              done_fail
);
    localparam int BUF_BYTES = DATA_BYTES + SPARE_BYTES;

    logic              map_ok, map_pair;
    logic [ADDR_W-1:0] map_a0, map_a1;
    byte_t             map_v0, map_v1;
    logic              rmw_idle, fail_q, end_pend;
    logic              accept, go, bad;

    // Handshake and launch decisions
    always_comb begin
        rep_ready = rmw_idle && !end_pend;
        accept    = rep_valid && rep_ready;
        go        = accept && map_ok && !fail_q;
        bad       = accept && !map_ok;
    end

    symfix_map #(
        .POS_W  (POS_W),
        .ADDR_W (ADDR_W),
        .MAX_POS(MAX_POS)
    ) u_map (
        .pos  (rep_pos),
        .pat  (rep_pat),
        .ok   (map_ok),
        .pair (map_pair),
        .addr0(map_a0),
        .val0 (map_v0),
        .addr1(map_a1),
        .val1 (map_v1)
    );

    symfix_rmw #(
        .ADDR_W(ADDR_W)
    ) u_rmw (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .pair     (map_pair),
        .addr0    (map_a0),
        .val0     (map_v0),
        .addr1    (map_a1),
        .val1     (map_v1),
        .idle     (rmw_idle),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    symfix_tally #(
        .CNT_W(CNT_W)
    ) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .ok_hit    (go),
        .bad_hit   (bad),
        .page_end  (page_end),
        .idle      (rmw_idle),
        .fail_q    (fail_q),
        .end_pend  (end_pend),
        .done      (done),
        .done_count(done_count),
        .done_fail (done_fail)
    );

    // R10
    no_write_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q |-> !mem_en);

    // R12
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_end |=> !rep_ready);

    // R8
    addr_in_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (int'(mem_addr) < BUF_BYTES));

    // R9
    launch_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (mem_en && !mem_we && !rep_ready));
endmodule

// File: tb/sim_symfix_apply.sv
// Bench: bit-offset reference model with an expected-access queue, checked every clock.
module sim_symfix_apply;
    localparam int BUF = 2112;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rep_valid = 1'b0;
    logic        rep_ready;
    logic [10:0] rep_pos = '0;
    logic [11:0] rep_pat = '0;
    logic        page_end = 1'b0;
    logic        mem_en, mem_we;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [7:0]  done_count;
    logic        done_fail;

    always #10 clk = ~clk;

    symfix_apply u0 (
        .clk(clk), .rst_n(rst_n), .rep_valid(rep_valid), .rep_ready(rep_ready),
        .rep_pos(rep_pos), .rep_pat(rep_pat), .page_end(page_end),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .done_count(done_count), .done_fail(done_fail)
    );

    logic [7:0] ram [0:BUF-1];
    logic [7:0] img [0:BUF-1];

    // Single-port byte RAM with one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF; i++) ram[i] <= 8'((i * 37 + 11) & 255);
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    int qa[$];
    int qw[$];
    int qv[$];
    string qt[$];
    int  exp_cnt = 0;
    bit  page_fail = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare every access against the expected queue
    int    m_a, m_w, m_v;
    string m_t;
    always @(negedge clk) begin
        if (rst_n && mem_en) begin
            if (qa.size() == 0) begin
                chk(0, "R9", "unexpected access addr", int'(mem_addr), -1);
            end else begin
                m_a = qa.pop_front(); m_w = qw.pop_front();
                m_v = qv.pop_front(); m_t = qt.pop_front();
                chk((int'(mem_addr) == m_a) && (int'(mem_we) == m_w), m_t, "access {we,addr}",
                    int'({mem_we, mem_addr}), (m_w << 12) | m_a);
                if (m_w == 1)
                    chk(int'(mem_wdata) == (int'(ram[m_a]) ^ m_v), m_t, "write data",
                        int'(mem_wdata), int'(ram[m_a]) ^ m_v);
            end
        end
    end

    // Model a report by bit offsets, queue expected accesses, then drive it
    task automatic send(int p, int pat, string tag);
        bit bad = (p > 1374) || (p == 0 && pat > 255);
        bit busy = !bad && !page_fail;
        if (bad) page_fail = 1;
        if (busy) begin
            int g0 = 12 * p - 4;
            int first = (g0 < 0 ? 0 : g0) / 8;
            int last = (12 * p + 7) / 8;
            int m0 = 0;
            int m1 = 0;
            exp_cnt++;
            for (int i = 0; i < 12; i++) begin
                if (((pat >> (11 - i)) & 1) == 1 && g0 + i >= 0) begin
                    int b = (g0 + i) / 8;
                    int sh = 7 - (g0 + i) % 8;
                    if (b == first) m0 |= (1 << sh);
                    else            m1 |= (1 << sh);
                end
            end
            qa.push_back(first); qw.push_back(0); qv.push_back(0);  qt.push_back(tag);
            qa.push_back(first); qw.push_back(1); qv.push_back(m0); qt.push_back(tag);
            img[first] = img[first] ^ 8'(m0);
            if (last != first) begin
                qa.push_back(last); qw.push_back(0); qv.push_back(0);  qt.push_back(tag);
                qa.push_back(last); qw.push_back(1); qv.push_back(m1); qt.push_back(tag);
                img[last] = img[last] ^ 8'(m1);
            end
        end
        @(negedge clk);
        while (!rep_ready) @(negedge clk);
        rep_valid = 1'b1;
        rep_pos   = 11'(p);
        rep_pat   = 12'(pat);
        @(negedge clk);
        rep_valid = 1'b0;
        // R9: busy after a launched report; dropped ones leave the block ready
        chk(rep_ready == !busy, busy ? "R9" : tag, "rep_ready after report",
            int'(rep_ready), int'(!busy));
    endtask

    // Close a page and check the strobe, the counts and the whole image
    task automatic end_page(string tag);
        bit seen = 0;
        int mism = 0;
        @(negedge clk);
        page_end = 1'b1;
        @(negedge clk);
        page_end = 1'b0;
        chk(rep_ready == 1'b0, "R12", "rep_ready after page_end", int'(rep_ready), 0);
        for (int k = 0; k < 40 && !seen; k++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        chk(seen, "R11", "done seen", int'(seen), 1);
        chk(int'(done_count) == exp_cnt, "R11", "done_count", int'(done_count), exp_cnt);
        chk(done_fail == page_fail, tag, "done_fail", int'(done_fail), int'(page_fail));
        @(negedge clk);
        chk(done == 1'b0, "R11", "done one cycle", int'(done), 0);
        chk(qa.size() == 0, tag, "accesses outstanding", qa.size(), 0);
        for (int i = 0; i < BUF; i++) if (ram[i] != img[i]) mism++;
        chk(mism == 0, tag, "buffer bytes differing", mism, 0);
        exp_cnt = 0;
        page_fail = 0;
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < BUF; i++) img[i] = 8'((i * 37 + 11) & 255);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rep_ready == 1'b1, "R1", "rep_ready", int'(rep_ready), 1);
        chk(mem_en == 1'b0, "R1", "mem_en", int'(mem_en), 0);
        chk(done == 1'b0, "R1", "done", int'(done), 0);

        // Page A: every position class, including a byte shared by two symbols
        send(1, 'hABC, "R2");
        send(2, 'h123, "R3");
        send(0, 'h05A, "R4");
        send(683, 'h3F1, "R2");
        send(1364, 'h456, "R3");
        send(1365, 'hF0F, "R7");
        send(1366, 'h7E1, "R8");
        send(1374, 'h9C3, "R8");
        send(1373, 'hFFF, "R8");
        end_page("R11");

        // Page B: short symbol with upper bits set, then a dropped report
        send(0, 'h1FF, "R5");
        send(5, 'h111, "R10");
        end_page("R5");

        // Page C: one good report, out-of-range position, then dropped reports
        send(3, 'h0A5, "R2");
        send(1375, 'h001, "R6");
        send(1, 'h800, "R10");
        send(2047, 'h800, "R10");
        end_page("R6");

        // Page D: empty page shows count and flag were cleared
        end_page("R11");

        // Page E: page_end while the last update is still in flight
        send(4, 'hFED, "R3");
        end_page("R12");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule